// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block turns a raw, possibly bouncing link-status signal into a qualified link-up flag. Link-up is declared only after the raw signal has stayed high, sample after sample, for a stability period. A 3-bit code picks the period from eight fixed durations, from instantaneous up to two seconds. Time is counted in microsecond ticks that an external tick generator supplies. Link-down is reported at once. A one-cycle pulse marks every change of the qualified flag, so that an event or interrupt source can be driven directly from it.

The period code is captured each time qualification restarts: at reset, and on every clock edge that samples the raw link low. A code change made while a count is running therefore applies only to the next qualification attempt. The parameter `SCALE_SHIFT` divides every duration by a power of two. With the default of 0 the periods are in true microseconds. Larger values shorten the periods for fast-clock emulation.

Top module: `link_stab_qual`

## Requirements
- R1: The period code selects a limit in microsecond ticks, shifted right by SCALE_SHIFT: code 0 = 0, 1 = 500, 2 = 1000, 3 = 64000, 4 = 256000, 5 = 512000, 6 = 1000000, 7 = 2000000.
- R2: With raw link high on every sampled edge, link_up rises on the edge that samples the N-th tick, where N is the captured limit. When N is 0, link_up rises on the first edge that samples raw link high.
- R3: Only edges that sample tick_us = 1 with raw link high advance qualification. Edges without a tick leave the progress unchanged.
- R4: Any edge that samples raw link low clears link_up on that edge and restarts qualification from zero.
- R5: The period code is captured at each restart (reset, or an edge sampling raw link low). Changes to period_code at any other time have no effect until the next restart.
- R6: After reset, link_up and link_chg are 0 and the captured limit is that of code 2 (1000 ticks), whatever value period_code has.
- R7: link_chg is 1 for exactly the cycle in which link_up holds a new value, and 0 otherwise.
- R8: Once link_up is 1, it stays 1 while raw link stays high, whatever tick_us and period_code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_raw | input | 1 | Unfiltered link status, 1 = up |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| period_code | input | 3 | Stability period selector |
| link_up | output | 1 | Qualified link-up flag |
| link_chg | output | 1 | One-cycle pulse on every link_up transition |

## Verification
The assertions check the following on every cycle: a low raw sample drops the flag and clears the count, the count never exceeds the captured limit, and the count holds on edges without a tick. They also check that the captured limit cannot move while the raw link stays high, that the flag is held while the link stays high, and that the change pulse lines up with flag transitions. The exact rise edge for each code can be shown only by the bench scenarios. The same holds for the reset default of code 2, for a code change made mid-count taking effect only after a restart, and for a glitch mid-count forcing a full requalification. The bench shows these with a cycle-accurate reference model and directed counts.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   localparam int unsigned CODE_W        = 3;
   localparam int unsigned NUM_CODES     = 1 << CODE_W;
   localparam int unsigned MAX_PERIOD_US = 2_000_000;
   localparam int unsigned DEFAULT_CODE  = 2;

   // unscaled stability period of each code, in microseconds
   function automatic int unsigned base_period_us(input int unsigned code);
      case (code)
         0:       return 0;
         1:       return 500;
         2:       return 1_000;
         3:       return 64_000;
         4:       return 256_000;
         5:       return 512_000;
         6:       return 1_000_000;
         default: return 2_000_000;
      endcase
   endfunction
endpackage

// File: rtl/lsq_period_table.sv
module lsq_period_table #(
   parameter int unsigned SCALE_SHIFT = 0,
   parameter int unsigned CNT_W       = 21
) (
   input  logic [lsq_pkg::CODE_W-1:0] code,
   output logic [CNT_W-1:0]           limit
);
   import lsq_pkg::*;

   logic [CNT_W-1:0] table_q [NUM_CODES];

   // one constant per code, scaled at elaboration
   for (genvar i = 0; i < NUM_CODES; i++) begin : g_entry
      assign table_q[i] = CNT_W'(base_period_us(i) >> SCALE_SHIFT);
   end

   assign limit = table_q[code];
endmodule

// File: rtl/lsq_qual_core.sv
module lsq_qual_core #(
   parameter int unsigned CNT_W     = 21,
   parameter int unsigned RESET_LIM = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_raw,
   input  logic             tick_us,
   input  logic [CNT_W-1:0] new_limit,
   output logic             up_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] lim_q
);
   logic [CNT_W-1:0] cnt_inc;
   logic             reached;

   always_comb begin
      cnt_inc = cnt_q + CNT_W'(tick_us);
      reached = (cnt_inc >= lim_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= CNT_W'(RESET_LIM);
         up_q  <= 1'b0;
      end else if (!link_raw) begin
         cnt_q <= '0;
         lim_q <= new_limit;
         up_q  <= 1'b0;
      end else if (!up_q) begin
         if (reached) begin
            up_q <= 1'b1;
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/lsq_change_pulse.sv
module lsq_change_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic pulse
);
   logic level_d;

   always_ff @(posedge clk) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign pulse = level ^ level_d;
endmodule

// File: rtl/link_stab_qual.sv
module link_stab_qual #(
   parameter int unsigned SCALE_SHIFT = 0,
   parameter int unsigned RESET_CODE  = lsq_pkg::DEFAULT_CODE
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        link_raw,
   input  logic                        tick_us,
   input  logic [lsq_pkg::CODE_W-1:0]  period_code,
   output logic                        link_up,
   output logic                        link_chg
);
   import lsq_pkg::*;

   localparam int unsigned MAX_TICKS = MAX_PERIOD_US >> SCALE_SHIFT;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
   localparam int unsigned RESET_LIM = base_period_us(RESET_CODE) >> SCALE_SHIFT;

   if (SCALE_SHIFT > 8) begin : g_bad_shift
      $error("SCALE_SHIFT above 8 collapses the 500 us period to zero");
   end
   if (RESET_CODE >= NUM_CODES) begin : g_bad_code
      $error("RESET_CODE out of range");
   end

   logic [CNT_W-1:0] sel_limit;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] lim_w;
   logic             up_w;

   lsq_period_table #(.SCALE_SHIFT(SCALE_SHIFT), .CNT_W(CNT_W)) u_table (
      .code  (period_code),
      .limit (sel_limit)
   );

   lsq_qual_core #(.CNT_W(CNT_W), .RESET_LIM(RESET_LIM)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_raw  (link_raw),
      .tick_us   (tick_us),
      .new_limit (sel_limit),
      .up_q      (up_w),
      .cnt_q     (cnt_w),
      .lim_q     (lim_w)
   );

   lsq_change_pulse u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .level (up_w),
      .pulse (link_chg)
   );

   assign link_up = up_w;
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
   parameter int unsigned CNT_W = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             link_raw,
   input logic             tick_us,
   input logic             link_up,
   input logic             link_chg,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] lim
);
   p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !link_raw |=> !link_up);

   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !link_raw |=> (cnt == '0));

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);

   p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (link_raw && !tick_us && !link_up && lim != '0) |=> $stable(cnt));

   p_lim_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      link_raw |=> $stable(lim));

   p_hold_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && link_raw) |=> link_up);

   p_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(link_raw));

   p_chg_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up != $past(link_up)) |-> link_chg);

   p_chg_only_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      link_chg |-> (link_up != $past(link_up)));
endmodule

bind link_stab_qual lsq_checker #(.CNT_W(CNT_W)) u_lsq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_raw (link_raw),
   .tick_us  (tick_us),
   .link_up  (link_up),
   .link_chg (link_chg),
   .cnt      (cnt_w),
   .lim      (lim_w)
);

// File: tb/tb_link_stab_qual.sv
module tb_link_stab_qual;
   localparam int SHIFT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_raw = 1'b1;
   logic       tick_us = 1'b1;
   logic [2:0] period_code = 3'd0;
   logic       link_up;
   logic       link_chg;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model state
   int  m_cnt = 0;
   int  m_lim = 0;
   bit  m_up = 0;
   bit  m_prev = 0;

   always #4 clk = ~clk;

   link_stab_qual #(.SCALE_SHIFT(SHIFT)) dut (
      .clk(clk), .rst_n(rst_n), .link_raw(link_raw), .tick_us(tick_us),
      .period_code(period_code), .link_up(link_up), .link_chg(link_chg)
   );

   // R1 durations, in microseconds, scaled like the design
   function automatic int ticks_of(input int code);
      int us[8] = '{0, 500, 1000, 64000, 256000, 512000, 1000000, 2000000};
      return us[code] >> SHIFT;
   endfunction

   task automatic chk(input bit got, input bit exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
      end
   endtask

   // behavioural model, stepped at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lim = ticks_of(2); m_up = 0; m_prev = 0;
      end else begin
         m_prev = m_up;
         if (!link_raw) begin
            m_cnt = 0; m_lim = ticks_of(int'(period_code)); m_up = 0;
         end else if (!m_up) begin
            if (m_cnt + int'(tick_us) >= m_lim) m_up = 1;
            else m_cnt = m_cnt + int'(tick_us);
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk(link_up, m_up, "R2/R4 model link_up");
         chk(link_chg, m_up != m_prev, "R7 model link_chg");
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // restart with given code, then count a full period with ticks every cycle
   task automatic qualify(input int code, input string req);
      int n;
      n = ticks_of(code);
      period_code = 3'(code);
      link_raw = 1'b0; tick_us = 1'b1;
      step(1);
      link_raw = 1'b1;
      step(n - 1);
      chk(link_up, 1'b0, req);
      step(1);
      chk(link_up, 1'b1, req);
      chk(link_chg, 1'b1, "R7 rise pulse");
   endtask

   initial begin
      step(3);
      chk(link_up, 1'b0, "R6 reset link_up");
      chk(link_chg, 1'b0, "R6 reset link_chg");
      rst_n = 1'b1;                         // code input 0, but reset limit is code 2
      step(ticks_of(2) - 1);
      chk(link_up, 1'b0, "R6 default period not yet");
      step(1);
      chk(link_up, 1'b1, "R6 default period reached");
      chk(link_chg, 1'b1, "R7 pulse on rise");
      step(1);
      chk(link_chg, 1'b0, "R7 pulse one cycle");

      // R4: single low sample drops at once
      link_raw = 1'b0; step(1);
      chk(link_up, 1'b0, "R4 immediate drop");
      chk(link_chg, 1'b1, "R7 pulse on fall");
      // R2: code 0 captured at that restart, instantaneous
      link_raw = 1'b1; step(1);
      chk(link_up, 1'b1, "R2 instantaneous code 0");

      // R8: hold while up, no ticks, code changed
      period_code = 3'd1; tick_us = 1'b0;
      step(20);
      chk(link_up, 1'b1, "R8 held while raw high");

      // R3: no ticks, no progress
      link_raw = 1'b0; step(1);
      link_raw = 1'b1; step(30);
      chk(link_up, 1'b0, "R3 no tick no qualification");
      tick_us = 1'b1;
      step(ticks_of(1) - 1);
      chk(link_up, 1'b0, "R3 ticks resume count");
      step(1);
      chk(link_up, 1'b1, "R1 code 1 period");

      // R5: code changed right after capture does not apply
      link_raw = 1'b0; step(1);
      link_raw = 1'b1; period_code = 3'd0;
      step(ticks_of(1) - 1);
      chk(link_up, 1'b0, "R5 captured code kept");
      step(1);
      chk(link_up, 1'b1, "R5 captured code reached");

      // R4: glitch mid-count restarts from zero
      period_code = 3'd1;
      link_raw = 1'b0; step(1);
      link_raw = 1'b1; step(5);
      link_raw = 1'b0; step(1);
      link_raw = 1'b1;
      step(ticks_of(1) - 1);
      chk(link_up, 1'b0, "R4 glitch restarts count");
      step(1);
      chk(link_up, 1'b1, "R4 full requalification");

      // R3: ticks on alternate cycles
      link_raw = 1'b0; step(1);
      link_raw = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tick_us = (i % 2) == 1;
         step(1);
      end
      chk(link_up, 1'b1, "R3 sparse ticks qualify");

      qualify(3, "R1 code 3 period");
      qualify(4, "R1 code 4 period");
      qualify(5, "R1 code 5 period");
      qualify(6, "R1 code 6 period");
      qualify(7, "R1 code 7 period");
      qualify(2, "R1 code 2 period");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule